// File: doc/BRIEF.md
# Derandomizing Readout Packer

This block sits between sixteen capture channels and a single 16-bit output bus. Each channel hands over complete events of one to four 16-bit words. Every channel has its own event queue that absorbs bursts of activity. A readout engine drains the queues onto the bus, and the receiver has no way to stall it: a word is pushed whenever the valid strobe is high. The last word of each event carries an end-of-event marker. On that same cycle the block pulses a clear line back to the channel that produced the event, which ends that channel's readout dead time.

Readout works in passes. At the start of a pass the engine takes a snapshot of which queues hold data. It then serves those channels, one event each, lowest channel number first. Each served channel costs one selection cycle plus one cycle per word. With single-word events, the first word appears two clock edges after the write, and each further fired channel adds two cycles. If all sixteen channels fire at once, the last word leaves 32 cycles after the write. A write to a queue that is already full is discarded, and the channel's overflow flag is set and stays set.

Top module: `readout_packer`

## Requirements
- R1: While reset is active and right after it ends, `out_valid`, `out_eoe`, every bit of `chan_clr` and every bit of `ovf` are 0.
- R2: An event is written by raising `evt_wr[c]` for one edge, with `evt_len` bits [2c+1:2c] holding the word count minus one and word j in `evt_data` bits [(4c+j)*16+15:(4c+j)*16]. When no other channel is pending, word 0 is on `out_data` with `out_valid` high after the second rising edge following the write edge. The remaining words follow on consecutive cycles, and `out_valid` is high for exactly that many cycles.
- R3: `out_eoe` is high on the last word of every event and low on every other word.
- R4: `chan_clr[c]` pulses for exactly one cycle, on the cycle that carries the end-of-event word of channel c. At most one clear bit is high at a time.
- R5: Each served event costs one idle selection cycle ahead of its words. When all 16 channels receive a one-word event on the same edge, the words appear 2, 4, ..., 32 edges after the write, with `out_valid` low in between.
- R6: Within one pass, fired channels are served in ascending channel order. A channel that still holds data after being served waits for the next pass, so higher channels captured in the snapshot go first.
- R7: Each channel queue holds 16 events (parameter `EVT_DEPTH`, 16 or 32). A write arriving while the queue is full is dropped and never appears on the bus, even if a read frees a slot on the same edge. In that case `ovf[c]` is set and stays set until reset.
- R8: Channels are independent. Writes to several channels on one edge are all kept, and an overflow on one channel sets no other channel's flag.
- R9: The events of one channel leave the block in the order they were written, with their words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Readout clock, shared by write and read sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_wr | input | 16 | Per-channel event write strobe |
| evt_len | input | 32 | Per-channel word count minus one, 2 bits per channel |
| evt_data | input | 1024 | Per-channel event words, 4 words of 16 bits per channel |
| out_data | output | 16 | Pushed output word |
| out_valid | output | 1 | High for one cycle per output word |
| out_eoe | output | 1 | Marks the last word of an event |
| chan_clr | output | 16 | One-cycle clear back to the channel whose event just finished |
| ovf | output | 16 | Sticky per-channel overflow flag |

## Verification
The hardest case to reach from the ports is a full queue, because the engine keeps draining whenever any data is present. The stimulus writes four-word events to one channel on every cycle, so each write costs the engine five cycles to drain. It also mixes in writes to another channel, and a long random phase loads all channels beyond what the engine can remove. The bench tracks each queue's occupancy from the writes it issues and the clears it observes. From that count it predicts which writes must be dropped, including those that meet a read on the same edge. It then checks the flags and the stream against that prediction.

// File: rtl/rp_pkg.sv
`timescale 1ns/1ps
package rp_pkg;
  typedef enum logic {
    ST_PICK = 1'b0,
    ST_SEND = 1'b1
  } rd_state_e;
endpackage

// File: rtl/rp_chan_fifo.sv
`timescale 1ns/1ps
module rp_chan_fifo #(
  parameter int DEPTH = 16,
  parameter int MAXW  = 4,
  parameter int DW    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [$clog2(MAXW)-1:0] wr_len,
  input  logic [MAXW*DW-1:0]   wr_words,
  input  logic                 pop,
  output logic                 nonempty,
  output logic [$clog2(MAXW)-1:0] head_len,
  output logic [MAXW*DW-1:0]   head_words,
  output logic                 ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(MAXW);
  localparam int EW = LW + MAXW*DW;

  logic [EW-1:0] mem [DEPTH];
  logic [AW:0]   wptr_q, wptr_d, rptr_q, rptr_d;
  logic          ovf_q, ovf_d;
  logic          full, wr_ok, rd_ok;

  assign full     = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign nonempty = (wptr_q != rptr_q);
  assign wr_ok    = wr && !full;
  assign rd_ok    = pop && nonempty;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    ovf_d  = ovf_q;
    if (wr_ok) wptr_d = wptr_q + {{AW{1'b0}}, 1'b1};
    if (rd_ok) rptr_d = rptr_q + {{AW{1'b0}}, 1'b1};
    if (wr && full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q[AW-1:0]] <= {wr_len, wr_words};
  end

  assign head_len   = mem[rptr_q[AW-1:0]][EW-1 -: LW];
  assign head_words = mem[rptr_q[AW-1:0]][MAXW*DW-1:0];
  assign ovf        = ovf_q;
endmodule

// File: rtl/rp_pick.sv
`timescale 1ns/1ps
module rp_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0]         req,
  output logic                 found,
  output logic [$clog2(N)-1:0] idx,
  output logic [N-1:0]         onehot
);
  localparam int IW = $clog2(N);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  assign onehot = req & (~req + {{(N-1){1'b0}}, 1'b1});
endmodule

// File: rtl/rp_readout.sv
`timescale 1ns/1ps
module rp_readout
  import rp_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int MAXW = 4,
  parameter int DW   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          nonempty,
  input  logic [$clog2(MAXW)-1:0] sel_len,
  input  logic [DW-1:0]           sel_word,
  output logic [$clog2(NCH)-1:0]  cur_ch,
  output logic [$clog2(MAXW)-1:0] widx,
  output logic [NCH-1:0]          pop,
  output logic [DW-1:0]           out_data,
  output logic                    out_valid,
  output logic                    out_eoe,
  output logic [NCH-1:0]          chan_clr
);
  localparam int CW = $clog2(NCH);
  localparam int LW = $clog2(MAXW);

  rd_state_e      state_q, state_d;
  logic [NCH-1:0] mask_q, mask_d, pmask, pick_1h, ch_1h;
  logic [CW-1:0]  ch_q, ch_d, pick_idx;
  logic [LW-1:0]  widx_q, widx_d;
  logic [DW-1:0]  data_q, data_d;
  logic           valid_q, valid_d, eoe_q, eoe_d;
  logic [NCH-1:0] clr_q, clr_d;
  logic           pick_found, last, data_en;

  assign pmask = (|mask_q) ? mask_q : nonempty;
  assign ch_1h = {{(NCH-1){1'b0}}, 1'b1} << ch_q;
  assign last  = (widx_q == sel_len);

  rp_pick #(.N(NCH)) u_pick (
    .req    (pmask),
    .found  (pick_found),
    .idx    (pick_idx),
    .onehot (pick_1h)
  );

  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    ch_d    = ch_q;
    widx_d  = widx_q;
    data_d  = data_q;
    valid_d = 1'b0;
    eoe_d   = 1'b0;
    clr_d   = '0;
    pop     = '0;
    data_en = 1'b0;
    case (state_q)
      ST_PICK: begin
        if (pick_found) begin
          ch_d    = pick_idx;
          mask_d  = pmask & ~pick_1h;
          widx_d  = '0;
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        data_en = 1'b1;
        data_d  = sel_word;
        valid_d = 1'b1;
        if (last) begin
          eoe_d   = 1'b1;
          clr_d   = ch_1h;
          pop     = ch_1h;
          state_d = ST_PICK;
        end else begin
          widx_d = widx_q + {{(LW-1){1'b0}}, 1'b1};
        end
      end
      default: state_d = ST_PICK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PICK;
      mask_q  <= '0;
      ch_q    <= '0;
      widx_q  <= '0;
      valid_q <= 1'b0;
      eoe_q   <= 1'b0;
      clr_q   <= '0;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_d;
      ch_q    <= ch_d;
      widx_q  <= widx_d;
      valid_q <= valid_d;
      eoe_q   <= eoe_d;
      clr_q   <= clr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign cur_ch    = ch_q;
  assign widx      = widx_q;
  assign out_data  = data_q;
  assign out_valid = valid_q;
  assign out_eoe   = eoe_q;
  assign chan_clr  = clr_q;
endmodule

// File: rtl/readout_packer.sv
`timescale 1ns/1ps
module readout_packer #(
  parameter int NCH       = 16,
  parameter int EVT_DEPTH = 16,
  parameter int MAXW      = 4,
  parameter int DW        = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         evt_wr,
  input  logic [NCH*$clog2(MAXW)-1:0] evt_len,
  input  logic [NCH*MAXW*DW-1:0] evt_data,
  output logic [DW-1:0]          out_data,
  output logic                   out_valid,
  output logic                   out_eoe,
  output logic [NCH-1:0]         chan_clr,
  output logic [NCH-1:0]         ovf
);
  localparam int CW = $clog2(NCH);
  localparam int LW = $clog2(MAXW);
  localparam int EWD = MAXW*DW;

  logic [1:0]     rst_pipe_q;
  logic           rst_sync_n;
  logic [NCH-1:0] nonempty, pop;
  logic [LW-1:0]  head_len [NCH];
  logic [EWD-1:0] head_words [NCH];
  logic [CW-1:0]  cur_ch;
  logic [LW-1:0]  widx, sel_len;
  logic [EWD-1:0] hw_sel;
  logic [DW-1:0]  sel_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    rp_chan_fifo #(.DEPTH(EVT_DEPTH), .MAXW(MAXW), .DW(DW)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .wr         (evt_wr[c]),
      .wr_len     (evt_len[c*LW +: LW]),
      .wr_words   (evt_data[c*EWD +: EWD]),
      .pop        (pop[c]),
      .nonempty   (nonempty[c]),
      .head_len   (head_len[c]),
      .head_words (head_words[c]),
      .ovf        (ovf[c])
    );
  end

  assign sel_len = head_len[cur_ch];
  assign hw_sel  = head_words[cur_ch];

  always_comb begin
    sel_word = hw_sel[DW-1:0];
    for (int j = 0; j < MAXW; j++) begin
      if (widx == LW'(j)) sel_word = hw_sel[j*DW +: DW];
    end
  end

  rp_readout #(.NCH(NCH), .MAXW(MAXW), .DW(DW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .nonempty  (nonempty),
    .sel_len   (sel_len),
    .sel_word  (sel_word),
    .cur_ch    (cur_ch),
    .widx      (widx),
    .pop       (pop),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_eoe   (out_eoe),
    .chan_clr  (chan_clr)
  );
endmodule

// File: rtl/rp_checker.sv
`timescale 1ns/1ps
module rp_checker #(
  parameter int NCH  = 16,
  parameter int MAXW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           out_valid,
  input logic           out_eoe,
  input logic [NCH-1:0] chan_clr,
  input logic [NCH-1:0] ovf
);
  localparam int RW = $clog2(MAXW + 1) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (!out_valid) run_q <= '0;
    else if (run_q < RW'(MAXW)) run_q <= run_q + 1'b1;
  end

  assert_burst_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (run_q < RW'(MAXW)));

  assert_eoe_on_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_eoe |-> out_valid);

  assert_clr_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_clr));

  assert_clr_at_eoe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_clr) |-> out_eoe);

  assert_gap_after_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_eoe |=> !out_valid);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf & $past(ovf)) == $past(ovf)));
endmodule

bind readout_packer rp_checker #(.NCH(NCH), .MAXW(MAXW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .out_valid (out_valid),
  .out_eoe   (out_eoe),
  .chan_clr  (chan_clr),
  .ovf       (ovf)
);

// File: tb/readout_packer_tb.sv
`timescale 1ns/1ps
module readout_packer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 16;
  localparam int DEPTH = 16;
  localparam int MAXW  = 4;
  localparam int DW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]         evt_wr = '0;
  logic [NCH*2-1:0]       evt_len = '0;
  logic [NCH*MAXW*DW-1:0] evt_data = '0;
  logic [DW-1:0]          out_data;
  logic                   out_valid, out_eoe;
  logic [NCH-1:0]         chan_clr, ovf;

  int n_chk = 0;
  int n_fail = 0;

  logic [65:0] exp_mem [NCH][32];
  int hd [NCH];
  int tl [NCH];
  logic [NCH-1:0] exp_ovf = '0;
  int seq = 0;
  int order_log [64];
  int n_log = 0;
  bit mon_en = 0;
  logic [DW-1:0] bw [MAXW];
  int bcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  readout_packer u_dut (
    .clk(clk), .rst_n(rst_n), .evt_wr(evt_wr), .evt_len(evt_len),
    .evt_data(evt_data), .out_data(out_data), .out_valid(out_valid),
    .out_eoe(out_eoe), .chan_clr(chan_clr), .ovf(ovf)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mkword(int ch, int sq, int j);
    return {4'(ch), 10'(sq), 2'(j)};
  endfunction

  // called one time unit after a falling edge; the write lands on the next rising edge
  task automatic set_evt(input int ch, input int nw);
    logic [65:0] e;
    e = '0;
    e[65:64] = 2'(nw - 1);
    evt_wr[ch] = 1'b1;
    evt_len[ch*2 +: 2] = 2'(nw - 1);
    for (int j = 0; j < MAXW; j++) begin
      evt_data[(ch*MAXW+j)*DW +: DW] = mkword(ch, seq, j);
      e[j*DW +: DW] = mkword(ch, seq, j);
    end
    if (tl[ch] - hd[ch] == DEPTH) exp_ovf[ch] = 1'b1;
    else begin
      exp_mem[ch][tl[ch] % 32] = e;
      tl[ch]++;
    end
    seq++;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
    evt_wr = '0;
  endtask

  task automatic drain();
    bit busy;
    for (int k = 0; k < 3000; k++) begin
      busy = out_valid;
      for (int c = 0; c < NCH; c++) if (hd[c] != tl[c]) busy = 1;
      if (!busy) break;
      step();
    end
    repeat (3) step();
  endtask

  // scoreboard on the pushed stream
  always @(negedge clk) begin
    if (mon_en) begin
      int ch;
      int len;
      logic [65:0] e;
      if (|chan_clr && !out_eoe)
        check(0, "R4", "clear without end-of-event", 32'(chan_clr), 0);
      if (out_valid) begin
        if (bcnt < MAXW) bw[bcnt] = out_data;
        bcnt++;
      end
      if (out_eoe) begin
        ch = 0;
        for (int i = 0; i < NCH; i++) if (chan_clr[i]) ch = i;
        check($onehot(chan_clr), "R4", "clear one-hot at end-of-event", 32'(chan_clr), 32'(1 << ch));
        if (hd[ch] == tl[ch]) begin
          check(0, "R7", "event not expected on this channel", 32'(ch), 32'hFFFF);
        end else begin
          e = exp_mem[ch][hd[ch] % 32];
          len = int'(e[65:64]) + 1;
          check(bcnt == len, "R2", "event word count", 32'(bcnt), 32'(len));
          for (int j = 0; j < MAXW; j++)
            if (j < len && j < bcnt)
              check(bw[j] == e[j*DW +: DW], "R9", "event word in order", 32'(bw[j]), 32'(e[j*DW +: DW]));
          hd[ch]++;
        end
        if (n_log < 64) begin
          order_log[n_log] = ch;
          n_log++;
        end
        bcnt = 0;
      end
    end
  end

  task automatic single_evt(input int ch, input int nw);
    set_evt(ch, nw);
    step();
    check(out_valid == 0, "R2", "no word one edge after write", 32'(out_valid), 0);
    step();
    check(out_valid == 0, "R2", "no word during pick", 32'(out_valid), 0);
    for (int j = 0; j < nw; j++) begin
      step();
      check(out_valid == 1, "R2", "word valid", 32'(out_valid), 1);
      check(out_data == mkword(ch, seq - 1, j), "R2", "word data", 32'(out_data), 32'(mkword(ch, seq - 1, j)));
      check(out_eoe == (j == nw - 1), "R3", "end-of-event position", 32'(out_eoe), 32'(j == nw - 1));
      check(chan_clr[ch] == (j == nw - 1), "R4", "clear timing", 32'(chan_clr), 32'(j == nw - 1));
    end
    step();
    check(out_valid == 0, "R2", "valid ends after last word", 32'(out_valid), 0);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin hd[c] = 0; tl[c] = 0; end
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_eoe == 0, "R1", "outputs in reset", {out_valid, out_eoe}, 0);
    check(chan_clr == 0 && ovf == 0, "R1", "clear/overflow in reset", {chan_clr, ovf}, 0);
    #1 rst_n = 1'b1;
    repeat (4) step();
    check(out_valid == 0 && chan_clr == 0 && ovf == 0, "R1", "idle after reset", {15'd0, out_valid, ovf}, 0);
    mon_en = 1;

    // sweep every channel and every event length
    for (int c = 0; c < NCH; c++)
      for (int nw = 1; nw <= MAXW; nw++)
        single_evt(c, nw);

    // all channels fire together with one-word events
    n_log = 0;
    for (int c = 0; c < NCH; c++) set_evt(c, 1);
    step();
    for (int k = 1; k <= 2*NCH; k++) begin
      step();
      if (k % 2 == 0) begin
        check(out_valid == 1 && out_eoe == 1, "R5", "word slot", {out_valid, out_eoe}, 3);
        check(out_data[15:12] == 4'((k - 2) / 2), "R6", "ascending channel", 32'(out_data[15:12]), 32'((k - 2) / 2));
      end else begin
        check(out_valid == 0, "R5", "selection gap", 32'(out_valid), 0);
      end
    end
    step();
    check(out_valid == 0, "R5", "idle after 32 cycles", 32'(out_valid), 0);
    drain();

    // channel served again only in the next pass
    n_log = 0;
    set_evt(2, 1);
    set_evt(7, 1);
    step();
    set_evt(2, 1);
    step();
    drain();
    check(n_log == 3, "R6", "served event count", 32'(n_log), 3);
    check(order_log[0] == 2 && order_log[1] == 7 && order_log[2] == 2, "R6", "pass order 2,7,2",
          {8'(order_log[0]), 8'(order_log[1]), 8'(order_log[2])}, 32'h020702);

    // overflow one channel while another keeps writing
    for (int k = 0; k < 40; k++) begin
      set_evt(3, 4);
      if (k % 5 == 0) set_evt(9, 2);
      step();
    end
    drain();
    check(exp_ovf[3] == 1, "R7", "model predicts overflow", 32'(exp_ovf[3]), 1);
    check(ovf[3] == 1, "R7", "overflow flag set", 32'(ovf[3]), 1);
    check(ovf[9] == 0, "R8", "other channel flag clear", 32'(ovf[9]), 0);
    check(ovf == exp_ovf, "R8", "overflow vector", 32'(ovf), 32'(exp_ovf));
    single_evt(3, 1);
    check(ovf[3] == 1, "R7", "overflow stays set", 32'(ovf[3]), 1);

    // random load on every channel
    for (int k = 0; k < 1200; k++) begin
      for (int c = 0; c < NCH; c++)
        if ($urandom_range(0, 15) == 0) set_evt(c, int'($urandom_range(1, 4)));
      step();
    end
    drain();
    check(ovf == exp_ovf, "R7", "overflow vector after load", 32'(ovf), 32'(exp_ovf));
    for (int c = 0; c < NCH; c++)
      check(hd[c] == tl[c], "R9", "all kept events delivered", 32'(tl[c] - hd[c]), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule